// File: doc/BRIEF.md
# Thermal Trip Threshold Monitor

This block watches the stream of 8-bit temperature codes arriving from an on-chip sensor front end and raises an interrupt when the temperature climbs past one of four trip points. Software programs one base threshold code and a small offset for each level. Each trip point is the sum of the base and that level's offset. A code raises a level only when it lies strictly above that level's trip point.

Software reaches every setting and result through a simple word-addressed register bus with a single-cycle write strobe and a combinational read path. The block keeps a short history of earlier codes, latches a sticky status bit for each enabled level that is crossed, and drives one level interrupt line. That line is meant for a rising-edge sensitive controller. Software clears status bits with a write-one mask. The per-level enable, status and clear bits sit four bit positions apart, at bits 0, 4, 8 and 12. A mode field in the control word starts and stops sampling. The calibration word from the fuse source and a ready flag are plain inputs and are shown read-only.

Top module: `thermtrip_mon`

## Requirements
- R1: After reset the control word reads 0x00000002 (stopped). Enable, status, current code, history, base threshold and offsets read zero, and `irq` is low.
- R2: Address 0x00 returns `trim_word` in bits [15:0], with the first calibration code in [7:0], the second in [15:8], and zeros above. Address 0x28 reads 1 while `sense_ready` is high and 0 while it is low.
- R3: The control word at 0x20 holds the mode in bits [1:0], a 4-bit gain in bits [11:8] and a 5-bit reference field in bits [28:24]. All other bits read 0. Mode 3 means running; every other mode value means stopped.
- R4: While running, each cycle with `sample_valid` high loads `sample_code` into the current-code register at 0x40, and the new value is readable from the next cycle.
- R5: Each accepted sample shifts the history. History 0 (0x60) takes the previous current code, and history k (0x60+4k) takes the old history k-1.
- R6: Trip point n is base (0x44) plus offset n (0x50+4n), summed without wrap-around. An accepted code sets status n only when it is strictly greater than trip point n; a code equal to the trip point does not set it.
- R7: A status bit can be set only if its enable bit in 0x70 (bit 4n) is 1 when the sample is accepted. Only bits 0, 4, 8 and 12 of the enable word are stored.
- R8: Status bits at 0x74 (bit 4n) stay set until software writes 0x78 with bit 4n set. Writing 0x1111 clears all four. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: While stopped, samples are ignored: the current code and history do not change, no status bit is set, and existing status bits are held.
- R10: `irq` is high exactly when some status bit is set while its enable bit is set. Clearing an enable bit drops `irq` but leaves the status bit set.
- R11: Writes to the read-only addresses (0x00, 0x28, 0x40, 0x60–0x6C, 0x74) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | New temperature code present this cycle |
| sample_code | input | 8 | Temperature code from the sensor front end |
| trim_word | input | 16 | Two calibration codes from the fuse source |
| sense_ready | input | 1 | Sensor front end ready |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The bench builds the block with its default parameters: four levels and four history entries, which is exactly the full register map. Every offset and history address is therefore decoded and checked. It places codes exactly on a trip point and one above it. It sets the base near the top of the code range so that a trip point sum passes 255. It issues a sample and a clear on the same bit in the same cycle to test which one wins.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    localparam int CODE_W = 8;
    localparam int GAIN_W = 4;
    localparam int REF_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int LANE   = 4;    // bit distance between level flags

    localparam logic [ADDR_W-1:0] ADR_TRIM  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_READY = 8'h28;
    localparam logic [ADDR_W-1:0] ADR_CUR   = 8'h40;
    localparam logic [ADDR_W-1:0] ADR_BASE  = 8'h44;
    localparam logic [ADDR_W-1:0] ADR_OFF0  = 8'h50;
    localparam logic [ADDR_W-1:0] ADR_HIST0 = 8'h60;
    localparam logic [ADDR_W-1:0] ADR_EN    = 8'h70;
    localparam logic [ADDR_W-1:0] ADR_STS   = 8'h74;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 8'h78;

    localparam int GAIN_LSB = 8;
    localparam int REF_LSB  = 24;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd2,
        MODE_RUN  = 2'd3
    } run_mode_e;

    typedef struct packed {
        logic [REF_W-1:0]  vref;
        logic [GAIN_W-1:0] gain;
        logic [1:0]        mode;
    } ctrl_t;

    // place flag i at bit LANE*i of a bus word
    function automatic logic [DATA_W-1:0] lane_spread(input logic [7:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) r[LANE*i] = v[i];
        return r;
    endfunction

    function automatic logic [7:0] lane_gather(input logic [DATA_W-1:0] w);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = w[LANE*i];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[1:0] = c.mode;
        r[GAIN_LSB +: GAIN_W] = c.gain;
        r[REF_LSB +: REF_W]   = c.vref;
        return r;
    endfunction

endpackage

// File: rtl/thermtrip_regs.sv
module thermtrip_regs
    import thermtrip_pkg::*;
#(
    parameter int NLVL = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wen,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output ctrl_t                       ctrl,
    output logic [CODE_W-1:0]           base_thr,
    output logic [NLVL-1:0][CODE_W-1:0] lvl_off,
    output logic [NLVL-1:0]             lvl_en,
    output logic [NLVL-1:0]             lvl_clr,
    output logic                        running
);

    logic [7:0] wr_flags;
    assign wr_flags = lane_gather(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.mode <= MODE_STOP;
            ctrl.gain <= '0;
            ctrl.vref <= '0;
            base_thr  <= '0;
            lvl_en    <= '0;
        end else if (wen) begin
            if (addr == ADR_CTRL) begin
                ctrl.mode <= wdata[1:0];
                ctrl.gain <= wdata[GAIN_LSB +: GAIN_W];
                ctrl.vref <= wdata[REF_LSB +: REF_W];
            end
            if (addr == ADR_BASE) base_thr <= wdata[CODE_W-1:0];
            if (addr == ADR_EN)   lvl_en   <= wr_flags[NLVL-1:0];
        end
    end

    for (genvar n = 0; n < NLVL; n++) begin : g_off
        localparam logic [ADDR_W-1:0] MY_ADR = ADR_OFF0 + ADDR_W'(LANE * n);
        always_ff @(posedge clk) begin
            if (rst)                       lvl_off[n] <= '0;
            else if (wen && addr == MY_ADR) lvl_off[n] <= wdata[CODE_W-1:0];
        end
    end

    assign lvl_clr = (wen && addr == ADR_CLR) ? wr_flags[NLVL-1:0] : '0;
    assign running = (ctrl.mode == MODE_RUN);

    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wen && addr == ADR_CTRL) |=> $stable(ctrl)); // R3

endmodule

// File: rtl/thermtrip_hist.sv
module thermtrip_hist
    import thermtrip_pkg::*;
#(
    parameter int HDEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          accept,
    input  logic [CODE_W-1:0]             code_in,
    output logic [CODE_W-1:0]             cur_code,
    output logic [HDEPTH-1:0][CODE_W-1:0] hist
);

    always_ff @(posedge clk) begin
        if (rst)         cur_code <= '0;
        else if (accept) cur_code <= code_in;
    end

    for (genvar k = 0; k < HDEPTH; k++) begin : g_tap
        logic [CODE_W-1:0] feed;
        if (k == 0) begin : g_head
            assign feed = cur_code;
        end else begin : g_body
            assign feed = hist[k-1];
        end
        always_ff @(posedge clk) begin
            if (rst)         hist[k] <= '0;
            else if (accept) hist[k] <= feed;
        end
    end

    AST_HIST_TAKES_CUR: assert property (@(posedge clk) disable iff (rst)
        accept |=> hist[0] == $past(cur_code)); // R5

    AST_IDLE_HOLDS_CODE: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cur_code) && $stable(hist)); // R9

endmodule

// File: rtl/thermtrip_trip.sv
module thermtrip_trip
    import thermtrip_pkg::*;
#(
    parameter int NLVL = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        accept,
    input  logic [CODE_W-1:0]           code_in,
    input  logic [CODE_W-1:0]           base_thr,
    input  logic [NLVL-1:0][CODE_W-1:0] lvl_off,
    input  logic [NLVL-1:0]             lvl_en,
    input  logic [NLVL-1:0]             lvl_clr,
    output logic [NLVL-1:0]             lvl_sts
);

    localparam int SUM_W = CODE_W + 1;

    for (genvar n = 0; n < NLVL; n++) begin : g_lvl
        logic [SUM_W-1:0] trip_pt;
        logic             above;
        logic             set_now;

        // one spare bit keeps base+offset from wrapping past the code range
        assign trip_pt = {1'b0, base_thr} + {1'b0, lvl_off[n]};
        assign above   = {1'b0, code_in} > trip_pt;
        assign set_now = accept && above && lvl_en[n];

        always_ff @(posedge clk) begin
            if (rst)             lvl_sts[n] <= 1'b0;
            else if (set_now)    lvl_sts[n] <= 1'b1;
            else if (lvl_clr[n]) lvl_sts[n] <= 1'b0;
        end

        AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
            $rose(lvl_sts[n]) |-> $past(lvl_en[n] && accept)); // R7

        AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $fell(lvl_sts[n]) |-> $past(lvl_clr[n])); // R8
    end

endmodule

// File: rtl/thermtrip_mon.sv
module thermtrip_mon
    import thermtrip_pkg::*;
#(
    parameter int NLVL   = 4,
    parameter int HDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic [7:0]        sample_code,
    input  logic [15:0]       trim_word,
    input  logic              sense_ready,
    input  logic              bus_wen,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    ctrl_t                       ctrl;
    logic [CODE_W-1:0]           base_thr;
    logic [NLVL-1:0][CODE_W-1:0] lvl_off;
    logic [NLVL-1:0]             lvl_en;
    logic [NLVL-1:0]             lvl_clr;
    logic [NLVL-1:0]             lvl_sts;
    logic                        running;
    logic                        accept;
    logic [CODE_W-1:0]           cur_code;
    logic [HDEPTH-1:0][CODE_W-1:0] hist;

    assign accept = running && sample_valid;

    thermtrip_regs #(.NLVL(NLVL)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wen      (bus_wen),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .base_thr (base_thr),
        .lvl_off  (lvl_off),
        .lvl_en   (lvl_en),
        .lvl_clr  (lvl_clr),
        .running  (running)
    );

    thermtrip_hist #(.HDEPTH(HDEPTH)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .code_in  (sample_code),
        .cur_code (cur_code),
        .hist     (hist)
    );

    thermtrip_trip #(.NLVL(NLVL)) u_trip (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .code_in  (sample_code),
        .base_thr (base_thr),
        .lvl_off  (lvl_off),
        .lvl_en   (lvl_en),
        .lvl_clr  (lvl_clr),
        .lvl_sts  (lvl_sts)
    );

    assign irq = |(lvl_sts & lvl_en);

    logic [7:0] en_flags, sts_flags;
    always_comb begin
        en_flags  = '0;
        sts_flags = '0;
        en_flags[NLVL-1:0]  = lvl_en;
        sts_flags[NLVL-1:0] = lvl_sts;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_TRIM)  bus_rdata = {16'h0000, trim_word};
        if (bus_addr == ADR_CTRL)  bus_rdata = ctrl_word(ctrl);
        if (bus_addr == ADR_READY) bus_rdata = {31'd0, sense_ready};
        if (bus_addr == ADR_CUR)   bus_rdata = {24'd0, cur_code};
        if (bus_addr == ADR_BASE)  bus_rdata = {24'd0, base_thr};
        if (bus_addr == ADR_EN)    bus_rdata = lane_spread(en_flags);
        if (bus_addr == ADR_STS)   bus_rdata = lane_spread(sts_flags);
        for (int n = 0; n < NLVL; n++)
            if (bus_addr == ADR_OFF0 + ADDR_W'(LANE * n)) bus_rdata = {24'd0, lvl_off[n]};
        for (int k = 0; k < HDEPTH; k++)
            if (bus_addr == ADR_HIST0 + ADDR_W'(LANE * k)) bus_rdata = {24'd0, hist[k]};
    end

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (lvl_sts != '0)); // R10

    AST_STOPPED_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (rst)
        !running |=> (lvl_sts & ~$past(lvl_sts)) == '0); // R9

endmodule

// File: tb/sim_thermtrip_mon.sv
`timescale 1ns/1ps
module sim_thermtrip_mon;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [7:0]  sample_code = '0;
    logic [15:0] trim_word = 16'hA55A;
    logic        sense_ready = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermtrip_mon u0 (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_code(sample_code),
        .trim_word(trim_word), .sense_ready(sense_ready), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic feed(input logic [7:0] c);
        @(negedge clk);
        sample_valid = 1'b1; sample_code = c;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1;
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h20, 32'h2);
        rd_chk("R1 en", 8'h70, 32'h0);
        rd_chk("R1 sts", 8'h74, 32'h0);
        rd_chk("R1 cur", 8'h40, 32'h0);
        rd_chk("R1 hist0", 8'h60, 32'h0);
        rd_chk("R1 base", 8'h44, 32'h0);
        rd_chk("R1 off3", 8'h5C, 32'h0);
        irq_chk("R1 irq", 1'b0);
    endtask

    task automatic t_trim_ready;
        rd_chk("R2 trim", 8'h00, 32'h0000A55A);
        rd_chk("R2 not ready", 8'h28, 32'h0);
        sense_ready = 1'b1;
        rd_chk("R2 ready", 8'h28, 32'h1);
        wr(8'h00, 32'hFFFFFFFF);
        wr(8'h28, 32'h0);
        rd_chk("R11 trim write", 8'h00, 32'h0000A55A);
        rd_chk("R11 ready write", 8'h28, 32'h1);
    endtask

    task automatic t_ctrl;
        wr(8'h20, 32'hFFFFFFFF);
        rd_chk("R3 ctrl fields", 8'h20, 32'h1F000F03);
        wr(8'h20, 32'h0A000503);
        rd_chk("R3 ctrl run", 8'h20, 32'h0A000503);
    endtask

    task automatic t_levels;
        wr(8'h44, 32'h40);
        wr(8'h50, 32'd0);
        wr(8'h54, 32'd5);
        wr(8'h58, 32'd10);
        wr(8'h5C, 32'd20);
        wr(8'h70, 32'h1111);
        feed(8'd64);
        rd_chk("R6 equal not set", 8'h74, 32'h0);
        rd_chk("R4 cur", 8'h40, 32'd64);
        feed(8'd65);
        rd_chk("R6 above lvl0", 8'h74, 32'h0001);
        feed(8'd74);
        rd_chk("R6 lvl1 not lvl2", 8'h74, 32'h0011);
        feed(8'd85);
        rd_chk("R6 all", 8'h74, 32'h1111);
        rd_chk("R4 cur 85", 8'h40, 32'd85);
        rd_chk("R5 hist0", 8'h60, 32'd74);
        rd_chk("R5 hist1", 8'h64, 32'd65);
        rd_chk("R5 hist2", 8'h68, 32'd64);
        rd_chk("R5 hist3", 8'h6C, 32'd0);
        irq_chk("R10 irq on", 1'b1);
    endtask

    task automatic t_clear;
        wr(8'h78, 32'h0010);
        rd_chk("R8 partial clear", 8'h74, 32'h1101);
        wr(8'h78, 32'h1111);
        rd_chk("R8 full clear", 8'h74, 32'h0);
        irq_chk("R8 irq off", 1'b0);
    endtask

    task automatic t_enable;
        wr(8'h70, 32'h0101);
        feed(8'd90);
        rd_chk("R7 gated", 8'h74, 32'h0101);
        wr(8'h70, 32'hFFFFFFFF);
        rd_chk("R7 en bits", 8'h70, 32'h1111);
        wr(8'h70, 32'h0);
        irq_chk("R10 irq dropped", 1'b0);
        rd_chk("R10 sts kept", 8'h74, 32'h0101);
        wr(8'h78, 32'h1111);
        wr(8'h70, 32'h1111);
    endtask

    task automatic t_wrap;
        wr(8'h44, 32'hF0);
        wr(8'h5C, 32'h20);
        feed(8'hFF);
        rd_chk("R6 no wrap", 8'h74, 32'h0111);
    endtask

    task automatic t_stopped;
        wr(8'h20, 32'h2);
        feed(8'd200);
        rd_chk("R9 cur held", 8'h40, 32'hFF);
        rd_chk("R9 hist held", 8'h60, 32'd90);
        rd_chk("R9 sts held", 8'h74, 32'h0111);
        wr(8'h78, 32'h1111);
        wr(8'h20, 32'h3);
    endtask

    task automatic t_readonly;
        wr(8'h74, 32'h1111);
        rd_chk("R11 sts write", 8'h74, 32'h0);
        wr(8'h40, 32'h12);
        rd_chk("R11 cur write", 8'h40, 32'hFF);
        wr(8'h60, 32'h34);
        rd_chk("R11 hist write", 8'h60, 32'd90);
    endtask

    task automatic t_collide;
        wr(8'h44, 32'h40);
        wr(8'h50, 32'h0);
        wr(8'h70, 32'h0001);
        feed(8'h50);
        rd_chk("R8 pre", 8'h74, 32'h1);
        @(negedge clk);
        sample_valid = 1'b1; sample_code = 8'h50;
        bus_wen = 1'b1; bus_addr = 8'h78; bus_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0; bus_wen = 1'b0;
        rd_chk("R8 set wins", 8'h74, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_trim_ready();
        t_ctrl();
        t_levels();
        t_clear();
        t_enable();
        t_wrap();
        t_stopped();
        t_readonly();
        t_collide();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule